// File: doc/BRIEF.md
# Converter Output Word Generator with Test Patterns

This block forms the 10-bit parallel word that a data converter presents on its output pins. In normal operation it passes the converted sample, which arrives in offset-binary form with a valid strobe. A 4-bit mode field can instead put one of several test words on the bus:

- a fixed level (midscale, positive full scale or negative full scale);
- a checkerboard;
- a word that alternates between all ones and all zeros;
- one of two pseudo-random bit sequences, of order 9 or order 23.

Both pseudo-random generators have a control bit that holds them at their seed.

Every word, whether sample or test pattern, then passes through a number-format stage and an optional inversion of all bits. The format stage gives offset binary, two's complement or Gray code. The result is registered once before it reaches the pins. The register fields are plain inputs here; the block drives them only as levels.

Top module: `adc_tp_out`

## Requirements
- R1: While `rst` is high at a rising edge, `dout_o` becomes 0x000 and `dout_vld_o` becomes 0 after that edge.
- R2: With `mode_i` = 0000 the output after a rising edge is the formatted `smp_i` sampled at that edge, and `dout_vld_o` equals `smp_vld_i` sampled at that edge (one cycle of latency).
- R3: Modes 0001, 0010 and 0011 produce the offset-binary words 0x200, 0x3FF and 0x000 respectively, before formatting.
- R4: Mode 0100 produces 0x155 and 0x2AA on alternate words, with 0x155 as the first word after reset or after any change of `mode_i`.
- R5: Mode 0111 produces 0x3FF and 0x000 on alternate words, with 0x3FF as the first word after reset or after any change of `mode_i`.
- R6: Mode 0110 produces the order-9 sequence (feedback x^9 + x^5 + 1) from a 10-bit history `h` that is seeded to all ones. The word is `h`. After each word `h` becomes {h[8:0], h[8]^h[4]}, but only while mode 0110 is selected. From the seed the words are 0x3FF, 0x3FE, 0x3FC, 0x3F8, 0x3F0, 0x3E0, 0x3C1.
- R7: Mode 0101 produces the order-23 sequence (x^23 + x^18 + 1) from a 23-bit history `g` that is seeded to all ones. The word is g[9:0]. After each word `g` becomes {g[21:0], g[22]^g[17]}, only while mode 0101 is selected.
- R8: While `pn9_rst_i` (or `pn23_rst_i`) is high, the matching generator's word is the seed 0x3FF and its history is reloaded with the seed. After release the sequence restarts with 0x3FF.
- R9: `fmt_i` = 00 gives offset binary unchanged, 01 gives two's complement (bit 9 inverted), 10 gives Gray code (w XOR w>>1), and 11 behaves as 00.
- R10: With `inv_i` high every bit of the formatted word is complemented; the inversion is applied after formatting.
- R11: In modes 0001 to 0111, `dout_vld_o` is 1 after each rising edge whatever `smp_vld_i` is.
- R12: Mode codes 1000 to 1111 behave exactly as mode 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_i | input | 10 | Converted sample, offset binary |
| smp_vld_i | input | 1 | Sample valid strobe |
| mode_i | input | 4 | Test mode select |
| fmt_i | input | 2 | Output number format select |
| inv_i | input | 1 | Invert all output bits |
| pn9_rst_i | input | 1 | Hold order-9 generator at seed |
| pn23_rst_i | input | 1 | Hold order-23 generator at seed |
| dout_o | output | 10 | Output word |
| dout_vld_o | output | 1 | Output word valid |

## Verification
Every result of this block is due exactly one rising edge after its inputs are presented. This covers the formatted sample, the test word, the valid flag, the pattern restart on a mode change, and the seed word while a generator hold bit is set. The bench changes all inputs at the falling edge. It then samples the outputs 2 ns after the following rising edge and compares them with the word its reference model derived from the inputs of that edge. The pattern phase and the sequence position advance one step per edge in the model, so a mode change or a released hold is checked on the very next word.

// File: rtl/adc_tp_pkg.sv
package adc_tp_pkg;

    typedef enum logic [3:0] {
        TM_NORMAL  = 4'd0,
        TM_MID     = 4'd1,
        TM_POSFS   = 4'd2,
        TM_NEGFS   = 4'd3,
        TM_CHECKER = 4'd4,
        TM_PN23    = 4'd5,
        TM_PN9     = 4'd6,
        TM_TOGGLE  = 4'd7
    } tmode_e;

    typedef enum logic [1:0] {
        FMT_OBIN = 2'd0,
        FMT_TWOS = 2'd1,
        FMT_GRAY = 2'd2,
        FMT_RSVD = 2'd3
    } ofmt_e;

endpackage

// File: rtl/adc_tp_prbs.sv
// Fibonacci pseudo-random generator with a history long enough to supply
// OUT_W of the most recently shifted bits.
module adc_tp_prbs #(
    parameter int unsigned ORDER = 9,
    parameter int unsigned TAP   = 5,
    parameter int unsigned OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             adv,
    output logic [OUT_W-1:0] word_o
);
    localparam int unsigned LEN = (ORDER > OUT_W) ? ORDER : OUT_W;

    logic [LEN-1:0] sr_d, sr_q;
    logic           fb;

    always_comb begin
        fb   = sr_q[ORDER-1] ^ sr_q[TAP-1];
        sr_d = sr_q;
        if (hold) begin
            sr_d = '1;
        end else if (adv) begin
            sr_d = {sr_q[LEN-2:0], fb};
        end
        word_o = hold ? '1 : sr_q[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '1;
        end else begin
            sr_q <= sr_d;
        end
    end

endmodule

// File: rtl/adc_tp_fmt.sv
// Number-format stage followed by optional inversion; purely combinational.
module adc_tp_fmt
    import adc_tp_pkg::*;
#(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] obin_i,
    input  logic [1:0]   fmt_i,
    input  logic         inv_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] conv;

    always_comb begin
        case (fmt_i)
            FMT_TWOS: conv = {~obin_i[W-1], obin_i[W-2:0]};
            FMT_GRAY: conv = obin_i ^ (obin_i >> 1);
            default:  conv = obin_i;
        endcase
        word_o = inv_i ? ~conv : conv;
    end

endmodule

// File: rtl/adc_tp_out.sv
module adc_tp_out
    import adc_tp_pkg::*;
#(
    parameter int unsigned W        = 10,
    parameter int unsigned PN_A_ORD = 9,
    parameter int unsigned PN_A_TAP = 5,
    parameter int unsigned PN_B_ORD = 23,
    parameter int unsigned PN_B_TAP = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] smp_i,
    input  logic         smp_vld_i,
    input  logic [3:0]   mode_i,
    input  logic [1:0]   fmt_i,
    input  logic         inv_i,
    input  logic         pn9_rst_i,
    input  logic         pn23_rst_i,
    output logic [W-1:0] dout_o,
    output logic         dout_vld_o
);
    function automatic logic [W-1:0] alt_word();
        logic [W-1:0] w;
        for (int i = 0; i < int'(W); i++) begin
            w[i] = (i % 2 == 0);
        end
        return w;
    endfunction

    localparam logic [W-1:0] CB_FIRST = alt_word();
    localparam logic [W-1:0] MID_CODE = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0] dout;
        logic         vld;
        logic [3:0]   pm;
        logic         ph;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] pn_a_word, pn_b_word;
    logic [W-1:0] sel_ob, fmt_word;
    logic         ph_cur, is_test;

    adc_tp_prbs #(.ORDER(PN_A_ORD), .TAP(PN_A_TAP), .OUT_W(W)) u_pn_a (
        .clk    (clk),
        .rst    (rst),
        .hold   (pn9_rst_i),
        .adv    (mode_i == TM_PN9),
        .word_o (pn_a_word)
    );

    adc_tp_prbs #(.ORDER(PN_B_ORD), .TAP(PN_B_TAP), .OUT_W(W)) u_pn_b (
        .clk    (clk),
        .rst    (rst),
        .hold   (pn23_rst_i),
        .adv    (mode_i == TM_PN23),
        .word_o (pn_b_word)
    );

    adc_tp_fmt #(.W(W)) u_fmt (
        .obin_i (sel_ob),
        .fmt_i  (fmt_i),
        .inv_i  (inv_i),
        .word_o (fmt_word)
    );

    // Pattern selection: a change of mode restarts the alternating patterns.
    always_comb begin
        ph_cur  = (mode_i != st_q.pm) ? 1'b0 : st_q.ph;
        is_test = !mode_i[3] && (mode_i[2:0] != 3'd0);
        case (mode_i)
            TM_MID:     sel_ob = MID_CODE;
            TM_POSFS:   sel_ob = '1;
            TM_NEGFS:   sel_ob = '0;
            TM_CHECKER: sel_ob = ph_cur ? ~CB_FIRST : CB_FIRST;
            TM_PN23:    sel_ob = pn_b_word;
            TM_PN9:     sel_ob = pn_a_word;
            TM_TOGGLE:  sel_ob = ph_cur ? '0 : '1;
            default:    sel_ob = smp_i;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.dout = fmt_word;
        st_d.vld  = is_test ? 1'b1 : smp_vld_i;
        st_d.pm   = mode_i;
        st_d.ph   = ~ph_cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o     = st_q.dout;
    assign dout_vld_o = st_q.vld;

endmodule

// File: rtl/adc_tp_out_chk.sv
module adc_tp_out_chk #(
    parameter int unsigned W = 10
) (
    input logic         clk,
    input logic         rst,
    input logic         smp_vld_i,
    input logic [3:0]   mode_i,
    input logic [1:0]   fmt_i,
    input logic         inv_i,
    input logic         pn9_rst_i,
    input logic [W-1:0] dout_o,
    input logic         dout_vld_o
);
    logic up_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q <= 1'b0;
        end else begin
            up_q <= 1'b1;
        end
    end

    // R11: test modes always flag the word valid
    a_r11_test_valid: assert property (@(posedge clk) disable iff (rst)
        (!mode_i[3] && mode_i[2:0] != 3'd0) |=> dout_vld_o);

    // R2: normal mode forwards the strobe one cycle later
    a_r2_normal_valid: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 4'd0) |=> (dout_vld_o == $past(smp_vld_i)));

    // R3: midscale in offset binary without inversion
    a_r3_midscale: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 4'd1 && fmt_i == 2'd0 && !inv_i)
        |=> (dout_o == {1'b1, {(W-1){1'b0}}}));

    // R5: steady toggle mode complements the word every cycle
    a_r5_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        (up_q && mode_i == 4'd7 && $past(mode_i) == 4'd7 && fmt_i == 2'd0
         && $past(fmt_i) == 2'd0 && inv_i == $past(inv_i))
        |=> (dout_o == ~$past(dout_o)));

    // R8: held order-9 generator shows its seed
    a_r8_pn9_hold: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 4'd6 && pn9_rst_i && fmt_i == 2'd0 && !inv_i)
        |=> (dout_o == {W{1'b1}}));

endmodule

bind adc_tp_out adc_tp_out_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_vld_i  (smp_vld_i),
    .mode_i     (mode_i),
    .fmt_i      (fmt_i),
    .inv_i      (inv_i),
    .pn9_rst_i  (pn9_rst_i),
    .dout_o     (dout_o),
    .dout_vld_o (dout_vld_o)
);

// File: tb/adc_tp_out_bench.sv
`timescale 1ns/1ps
module adc_tp_out_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] smp = '0;
    logic       smp_vld = 1'b0;
    logic [3:0] mode = '0;
    logic [1:0] fmt = '0;
    logic       inv = 1'b0;
    logic       p9r = 1'b0;
    logic       p23r = 1'b0;
    logic [9:0] dout;
    logic       dout_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [3:0]  m_pm;
    logic        m_ph;
    logic [9:0]  m_h9;
    logic [22:0] m_h23;
    logic [9:0]  e_dout;
    logic        e_vld;

    always #4 clk = ~clk;

    adc_tp_out u_adc_tp_out (
        .clk        (clk),
        .rst        (rst),
        .smp_i      (smp),
        .smp_vld_i  (smp_vld),
        .mode_i     (mode),
        .fmt_i      (fmt),
        .inv_i      (inv),
        .pn9_rst_i  (p9r),
        .pn23_rst_i (p23r),
        .dout_o     (dout),
        .dout_vld_o (dout_vld)
    );

    function automatic logic [9:0] fmt_f(input logic [9:0] w, input logic [1:0] f,
                                         input logic iv);
        logic [9:0] c;
        if (f == 2'd1)      c = w ^ 10'h200;
        else if (f == 2'd2) c = w ^ {1'b0, w[9:1]};
        else                c = w;
        return iv ? ~c : c;
    endfunction

    function automatic string tag_of(input logic [3:0] m);
        if (m >= 4'd8) return "R12";
        case (m)
            4'd0: return "R2";
            4'd4: return "R4";
            4'd5: return "R7";
            4'd6: return "R6";
            4'd7: return "R5";
            default: return "R3";
        endcase
    endfunction

    task automatic model_reset();
        m_pm  = '0;
        m_ph  = 1'b0;
        m_h9  = '1;
        m_h23 = '1;
    endtask

    task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%03h expected 0x%03h at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply inputs at the falling edge, advance the model, sample after the rising edge.
    task automatic step(input logic [3:0] m, input logic [1:0] f, input logic iv,
                        input logic [9:0] s, input logic sv, input logic a9,
                        input logic a23);
        logic       phc;
        logic [9:0] ob, w9, w23;
        @(negedge clk);
        mode = m; fmt = f; inv = iv; smp = s; smp_vld = sv; p9r = a9; p23r = a23;
        phc = (m != m_pm) ? 1'b0 : m_ph;
        w9  = a9  ? 10'h3FF : m_h9;
        w23 = a23 ? 10'h3FF : m_h23[9:0];
        case (m)
            4'd1: ob = 10'h200;
            4'd2: ob = 10'h3FF;
            4'd3: ob = 10'h000;
            4'd4: ob = phc ? 10'h2AA : 10'h155;
            4'd5: ob = w23;
            4'd6: ob = w9;
            4'd7: ob = phc ? 10'h000 : 10'h3FF;
            default: ob = s;
        endcase
        e_dout = fmt_f(ob, f, iv);
        e_vld  = (m >= 4'd1 && m <= 4'd7) ? 1'b1 : sv;
        m_ph = ~phc;
        m_pm = m;
        if (a9) m_h9 = '1;
        else if (m == 4'd6) m_h9 = {m_h9[8:0], m_h9[8] ^ m_h9[4]};
        if (a23) m_h23 = '1;
        else if (m == 4'd5) m_h23 = {m_h23[21:0], m_h23[22] ^ m_h23[17]};
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk("R1", dout, 10'h000);
        chk("R1", {9'd0, dout_vld}, 10'd0);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        int unsigned seed_v;
        logic [3:0] rm;
        logic [1:0] rf;
        logic       ri;
        seed_v = $urandom(32'h5EED);
        model_reset();
        do_reset();

        // R6: order-9 sequence from seed
        begin
            logic [9:0] pn9_ref [7] = '{10'h3FF, 10'h3FE, 10'h3FC, 10'h3F8,
                                        10'h3F0, 10'h3E0, 10'h3C1};
            for (int i = 0; i < 7; i++) begin
                step(4'd6, 2'd0, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0);
                chk("R6", dout, pn9_ref[i]);
            end
        end
        // R7: order-23 sequence from seed
        begin
            logic [9:0] pn23_ref [4] = '{10'h3FF, 10'h3FE, 10'h3FC, 10'h3F8};
            for (int i = 0; i < 4; i++) begin
                step(4'd5, 2'd0, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0);
                chk("R7", dout, pn23_ref[i]);
            end
        end
        // R8: hold order-9 generator, then release restarts from seed
        for (int i = 0; i < 3; i++) begin
            step(4'd6, 2'd0, 1'b0, 10'h0, 1'b0, 1'b1, 1'b0);
            chk("R8", dout, 10'h3FF);
        end
        step(4'd6, 2'd0, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0);
        chk("R8", dout, 10'h3FF);
        step(4'd6, 2'd0, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0);
        chk("R8", dout, 10'h3FE);
        // R4 and R5: alternation and restart on mode change
        step(4'd4, 2'd0, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0); chk("R4", dout, 10'h155);
        step(4'd4, 2'd0, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0); chk("R4", dout, 10'h2AA);
        step(4'd4, 2'd0, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0); chk("R4", dout, 10'h155);
        step(4'd4, 2'd0, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0); chk("R4", dout, 10'h2AA);
        step(4'd7, 2'd0, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0); chk("R5", dout, 10'h3FF);
        step(4'd7, 2'd0, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0); chk("R5", dout, 10'h000);
        step(4'd4, 2'd0, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0); chk("R4", dout, 10'h155);
        // R3 and R9: fixed levels through each format
        step(4'd1, 2'd1, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0); chk("R9", dout, 10'h000);
        step(4'd1, 2'd2, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0); chk("R9", dout, 10'h300);
        step(4'd1, 2'd3, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0); chk("R9", dout, 10'h200);
        step(4'd2, 2'd1, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0); chk("R3", dout, 10'h1FF);
        step(4'd3, 2'd1, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0); chk("R3", dout, 10'h200);
        // R10: inversion after format
        step(4'd1, 2'd0, 1'b1, 10'h0, 1'b0, 1'b0, 1'b0); chk("R10", dout, 10'h1FF);
        step(4'd0, 2'd1, 1'b1, 10'h2C5, 1'b1, 1'b0, 1'b0); chk("R10", dout, 10'h33A);
        // R2: normal data
        step(4'd0, 2'd2, 1'b0, 10'h2C5, 1'b1, 1'b0, 1'b0);
        chk("R2", dout, 10'h3A7);
        chk("R2", {9'd0, dout_vld}, 10'd1);
        step(4'd0, 2'd1, 1'b0, 10'h2C5, 1'b0, 1'b0, 1'b0);
        chk("R2", dout, 10'h0C5);
        chk("R2", {9'd0, dout_vld}, 10'd0);
        // R11: test mode valid ignores the strobe
        step(4'd2, 2'd0, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0);
        chk("R11", {9'd0, dout_vld}, 10'd1);
        // R12: unused codes act as normal data
        step(4'd9, 2'd0, 1'b0, 10'h123, 1'b0, 1'b0, 1'b0);
        chk("R12", dout, 10'h123);
        chk("R12", {9'd0, dout_vld}, 10'd0);
        step(4'd12, 2'd1, 1'b0, 10'h123, 1'b1, 1'b0, 1'b0);
        chk("R12", dout, 10'h323);
        chk("R12", {9'd0, dout_vld}, 10'd1);

        // constrained random phase against the model
        rm = 4'd0; rf = 2'd1; ri = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            if (n == 2000) do_reset();
            if ($urandom % 8 == 0)  rm = 4'($urandom % 16);
            if ($urandom % 16 == 0) rf = 2'($urandom % 4);
            if ($urandom % 16 == 0) ri = ~ri;
            step(rm, rf, ri, 10'($urandom), 1'($urandom), ($urandom % 32 == 0),
                 ($urandom % 32 == 0));
            chk(tag_of(mode), dout, e_dout);
            chk((mode >= 4'd1 && mode <= 4'd7) ? "R11" : "R2",
                {9'd0, dout_vld}, {9'd0, e_vld});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule